// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral guards a system against hung software with a 32-bit down-counter that software must service. It is reached through a simple APB-style register port that completes in its access phase with no wait states. The counter loads from a programmable reload value and counts down once for each cycle in which the tick-enable input is high and counting is enabled. The first time the counter expires, the block raises an interrupt and restarts from the reload value. If that interrupt is still pending when the counter expires a second time, and the reset output is enabled, the block asserts a system reset request. That request stays set until the block itself is reset. The worst-case time to a reset is therefore two full load periods.

Software guards against stray writes through a guard register. Only a 32-bit key unlocks the block. Any other value written there locks it again. While the block is locked, every write to another register is dropped.

The escalation is a three-state machine. In QUIET nothing is pending. In WARNED the interrupt is pending. FIRED is final and holds the reset request. The transitions are: QUIET to WARNED on a first expiry (`first_expiry`); WARNED to QUIET on a clear write (`serviced`); WARNED to FIRED on an expiry while reset is enabled (`escalate`); WARNED stays in WARNED on an expiry while reset is disabled (`rearm`); and FIRED absorbs every event (`latched`).

Top module: `wdog_twostage`

## Requirements
- R1: After reset the block is locked (guard reads 1), the reload value and counter read 0xFFFFFFFF, control reads 0, raw and masked status read 0, and both `irq` and `rst_req` are low.
- R2: Register offsets are fixed because software decodes them. They are:
  - reload value at 0x000
  - counter value at 0x004
  - control at 0x008, with bit 0 as count/interrupt enable and bit 1 as reset enable
  - clear at 0x00C
  - raw status at 0x010, bit 0
  - masked status at 0x014, bit 0
  - guard at 0xC00, bit 0 meaning locked

  Control bits 31:2, the clear register and any unmapped offset all read as zero.
- R3: Writing exactly 0x1ACCE551 to the guard register unlocks the block. Writing any other value locks it.
- R4: While the block is locked, writes to any offset other than the guard register leave every register, the counter and the pending interrupt unchanged.
- R5: The counter decrements by one on each clock edge where `tick_en` is high and control bit 0 is set. Otherwise it holds its value.
- R6: An enabled tick while the counter reads 0 is an expiry. An expiry reloads the counter from the reload value, so a reload value L gives L+1 ticks per period. The first expiry sets the raw interrupt status.
- R7: An expiry while the interrupt is pending asserts `rst_req` if control bit 1 is set. If bit 1 is clear, the expiry only reloads the counter and the interrupt stays pending.
- R8: Once `rst_req` is asserted, it and the raw status stay high until reset, and clear writes have no effect on them.
- R9: A write to the clear register drops the pending interrupt and reloads the counter. When it coincides with an expiry, the clear write wins.
- R10: A write to the reload register reloads the counter with the new value at once. A control write with bit 0 set reloads the counter from the reload value.
- R11: Masked status and `irq` are high only when raw status is high and control bit 0 is set. Raw status is independent of the enable.
- R12: Writes to the counter, raw status and masked status offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count qualifier; one decrement per high cycle |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | 12 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational on paddr |
| irq | output | 1 | Level interrupt, equal to masked status |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench sweeps small reload values, each with the reset output both enabled and disabled, and checks the counter after every tick against L minus the tick count. An off-by-one in the expiry compare would shift the interrupt by one tick. A design that escalated without checking that the interrupt was pending, or that ignored reset enable, would move or drop the reset request. The bench also lands a clear write on the same edge as an expiry; a design that gives the expiry priority would reset the system at that edge. It also tries clears after the reset has fired, where a non-sticky design would release the request. Writes while locked and writes to read-only offsets are read back, so a missing lock qualifier or a decoder that accepts everything shows up as a changed value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] OFF_RELOAD = 12'h000;
    localparam logic [AW-1:0] OFF_COUNT  = 12'h004;
    localparam logic [AW-1:0] OFF_CTRL   = 12'h008;
    localparam logic [AW-1:0] OFF_ACK    = 12'h00C;
    localparam logic [AW-1:0] OFF_RAW    = 12'h010;
    localparam logic [AW-1:0] OFF_MSK    = 12'h014;
    localparam logic [AW-1:0] OFF_GUARD  = 12'hC00;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    // escalation stages of the watchdog
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_WARNED = 2'd1,
        ST_FIRED  = 2'd2
    } stage_e;

    typedef struct packed {
        logic rst_en;
        logic run_en;
    } ctrl_t;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              raw_st,
    input  logic              msk_st,
    output logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] load_q,
    output ctrl_t             ctrl_q,
    output logic              locked_q,
    output logic              reload_req,
    output logic [DATA_W-1:0] reload_val,
    output logic              clear_req
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] KEY      = DATA_W'(UNLOCK_KEY);

    logic wr_any;
    logic wr_ok;
    logic hit_reload;
    logic hit_ctrl;
    logic hit_ack;
    logic hit_guard;

    assign wr_any     = psel && penable && pwrite;
    assign wr_ok      = wr_any && !locked_q;
    assign hit_reload = (paddr == ADDR_W'(OFF_RELOAD));
    assign hit_ctrl   = (paddr == ADDR_W'(OFF_CTRL));
    assign hit_ack    = (paddr == ADDR_W'(OFF_ACK));
    assign hit_guard  = (paddr == ADDR_W'(OFF_GUARD));

    // guard register: key unlocks, anything else locks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
        end else if (wr_any && hit_guard) begin
            locked_q <= (pwdata != KEY);
        end
    end

    // reload value and control bits, only while unlocked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= ALL_ONES;
            ctrl_q <= '0;
        end else if (wr_ok) begin
            if (hit_reload) begin
                load_q <= pwdata;
            end
            if (hit_ctrl) begin
                ctrl_q.run_en <= pwdata[0];
                ctrl_q.rst_en <= pwdata[1];
            end
        end
    end

    // requests towards the counter core
    always_comb begin
        reload_req = 1'b0;
        reload_val = load_q;
        clear_req  = 1'b0;
        if (wr_ok) begin
            if (hit_reload) begin
                reload_req = 1'b1;
                reload_val = pwdata;
            end
            if (hit_ctrl && pwdata[0]) begin
                reload_req = 1'b1;
            end
            if (hit_ack) begin
                clear_req = 1'b1;
            end
        end
    end

    // read decode
    always_comb begin
        prdata = '0;
        unique case (paddr)
            ADDR_W'(OFF_RELOAD): prdata = load_q;
            ADDR_W'(OFF_COUNT):  prdata = cnt_val;
            ADDR_W'(OFF_CTRL):   prdata = DATA_W'({ctrl_q.rst_en, ctrl_q.run_en});
            ADDR_W'(OFF_RAW):    prdata = DATA_W'(raw_st);
            ADDR_W'(OFF_MSK):    prdata = DATA_W'(msk_st);
            ADDR_W'(OFF_GUARD):  prdata = DATA_W'(locked_q);
            default:             prdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_stage_core.sv
module wdog_stage_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    input  logic             rst_en,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             clear_req,
    output logic [CNT_W-1:0] count_q,
    output logic             raw_pend,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    stage_e state_q;
    stage_e state_d;
    logic   step;
    logic   at_zero;
    logic   expire;

    assign step    = tick_en && run_en;
    assign at_zero = (count_q == '0);
    // a register write on the same edge takes priority over the tick
    assign expire  = step && at_zero && !reload_req && !clear_req;

    // down-counter with reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= ALL_ONES;
        end else if (reload_req || clear_req) begin
            count_q <= reload_val;
        end else if (step) begin
            count_q <= at_zero ? reload_val : count_q - 1'b1;
        end
    end

    // stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // stage transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (expire) begin
                    state_d = ST_WARNED;       // first_expiry
                end
            end
            ST_WARNED: begin
                if (clear_req) begin
                    state_d = ST_QUIET;        // serviced
                end else if (expire && rst_en) begin
                    state_d = ST_FIRED;        // escalate
                end else begin
                    state_d = ST_WARNED;       // rearm or wait
                end
            end
            ST_FIRED: begin
                state_d = ST_FIRED;            // latched
            end
            default: begin
                state_d = ST_QUIET;
            end
        endcase
    end

    // stage outputs
    always_comb begin
        raw_pend = 1'b0;
        fire     = 1'b0;
        unique case (state_q)
            ST_QUIET: begin
                raw_pend = 1'b0;
                fire     = 1'b0;
            end
            ST_WARNED: begin
                raw_pend = 1'b1;
                fire     = 1'b0;
            end
            ST_FIRED: begin
                raw_pend = 1'b1;
                fire     = 1'b1;
            end
            default: begin
                raw_pend = 1'b0;
                fire     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq,
    output logic              rst_req
);

    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] reload_val;
    ctrl_t             ctrl_q;
    logic              locked_q;
    logic              reload_req;
    logic              clear_req;
    logic              raw_pend;
    logic              masked;
    logic              fire;

    assign masked  = raw_pend && ctrl_q.run_en;
    assign irq     = masked;
    assign rst_req = fire;

    wdog_regfile #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .cnt_val    (count_q),
        .raw_st     (raw_pend),
        .msk_st     (masked),
        .prdata     (prdata),
        .load_q     (load_q),
        .ctrl_q     (ctrl_q),
        .locked_q   (locked_q),
        .reload_req (reload_req),
        .reload_val (reload_val),
        .clear_req  (clear_req)
    );

    wdog_stage_core #(
        .CNT_W(DATA_W)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .run_en     (ctrl_q.run_en),
        .rst_en     (ctrl_q.rst_en),
        .reload_req (reload_req),
        .reload_val (reload_val),
        .clear_req  (clear_req),
        .count_q    (count_q),
        .raw_pend   (raw_pend),
        .fire       (fire)
    );

endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
    import wdog_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              rst_req,
    input logic              locked_q,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] count_q,
    input logic              raw_pend,
    input ctrl_t             ctrl_q
);

    logic wr_any;
    assign wr_any = psel && penable && pwrite;

    // R8: reset request never drops once set
    a_r8_fired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R7: escalation needs a pending interrupt and reset enable
    a_r7_fire_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(raw_pend && ctrl_q.rst_en));

    // R6: raw status rises only on an enabled tick at zero
    a_r6_raw_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_pend) |-> $past(tick_en && ctrl_q.run_en && count_q == '0));

    // R4: locked writes leave reload and control alone
    a_r4_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_any && paddr != ADDR_W'(OFF_GUARD))
        |=> ($stable(load_q) && $stable(ctrl_q)));

    // R3: the key unlocks
    a_r3_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && paddr == ADDR_W'(OFF_GUARD) && pwdata == DATA_W'(UNLOCK_KEY))
        |=> !locked_q);

    // R5: no tick and no write means the counter holds
    a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_any) |=> $stable(count_q));

endmodule

bind wdog_twostage wdog_twostage_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .rst_req  (rst_req),
    .locked_q (locked_q),
    .load_q   (load_q),
    .count_q  (count_q),
    .raw_pend (raw_pend),
    .ctrl_q   (ctrl_q)
);

// File: tb/wdog_twostage_tb_top.sv
module wdog_twostage_tb_top;
    import wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdog_twostage dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq     (irq),
        .rst_req (rst_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit tk = 1'b0);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1; tick_en = tk;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        paddr = a; psel = 1'b1; pwrite = 1'b0; penable = 1'b0;
        #1;
        check(tag, prdata, exp);
        psel = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rdchk("R1 guard", OFF_GUARD, 32'h1);
        rdchk("R1 reload", OFF_RELOAD, 32'hFFFF_FFFF);
        rdchk("R1 count", OFF_COUNT, 32'hFFFF_FFFF);
        rdchk("R1 ctrl", OFF_CTRL, 32'h0);
        rdchk("R1 raw", OFF_RAW, 32'h0);
        rdchk("R1 msk", OFF_MSK, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 rst_req", 32'(rst_req), 32'h0);

        // R4 locked writes dropped
        wr(OFF_RELOAD, 32'h5);
        rdchk("R4 reload", OFF_RELOAD, 32'hFFFF_FFFF);
        rdchk("R4 count", OFF_COUNT, 32'hFFFF_FFFF);
        wr(OFF_CTRL, 32'h3);
        rdchk("R4 ctrl", OFF_CTRL, 32'h0);

        // R3 key handling
        wr(OFF_GUARD, 32'h1ACC_E550);
        rdchk("R3 wrong key", OFF_GUARD, 32'h1);
        wr(OFF_GUARD, UNLOCK_KEY);
        rdchk("R3 unlock", OFF_GUARD, 32'h0);
        wr(OFF_GUARD, 32'h0);
        rdchk("R3 relock", OFF_GUARD, 32'h1);
        wr(OFF_GUARD, UNLOCK_KEY);

        // R2 decode
        wr(OFF_CTRL, 32'hFFFF_FFFC);
        rdchk("R2 reserved", OFF_CTRL, 32'h0);
        wr(OFF_CTRL, 32'hFFFF_FFFF);
        rdchk("R2 ctrl bits", OFF_CTRL, 32'h3);
        wr(OFF_CTRL, 32'h0);
        rdchk("R2 ack reads 0", OFF_ACK, 32'h0);
        rdchk("R2 unmapped", 12'h800, 32'h0);

        // R10 and R12
        wr(OFF_RELOAD, 32'h7);
        rdchk("R10 load reloads", OFF_COUNT, 32'h7);
        wr(OFF_COUNT, 32'h55);
        rdchk("R12 count ro", OFF_COUNT, 32'h7);
        wr(OFF_RAW, 32'h1);
        rdchk("R12 raw ro", OFF_RAW, 32'h0);
        wr(OFF_MSK, 32'h1);
        rdchk("R12 msk ro", OFF_MSK, 32'h0);

        // R5 hold and count
        ticks(3);
        rdchk("R5 disabled hold", OFF_COUNT, 32'h7);
        wr(OFF_CTRL, 32'h1);
        ticks(3);
        rdchk("R5 counted", OFF_COUNT, 32'h4);
        wr(OFF_CTRL, 32'h1);
        rdchk("R10 ctrl reload", OFF_COUNT, 32'h7);
        wr(OFF_CTRL, 32'h0);
        ticks(2);
        rdchk("R5 hold after disable", OFF_COUNT, 32'h7);
        wr(OFF_RELOAD, 32'hFFFF_FFFF);
        wr(OFF_CTRL, 32'h1);
        ticks(2);
        rdchk("R5 max load", OFF_COUNT, 32'hFFFF_FFFD);

        // sweep over small reload values and reset enable
        for (int lv = 0; lv < 4; lv++) begin
            for (int re = 0; re < 2; re++) begin
                do_reset();
                wr(OFF_GUARD, UNLOCK_KEY);
                wr(OFF_RELOAD, 32'(lv));
                wr(OFF_CTRL, 32'(re * 2 + 1));
                for (int k = 1; k <= lv; k++) begin
                    ticks(1);
                    rdchk("R5 sweep step", OFF_COUNT, 32'(lv - k));
                end
                rdchk("R6 no early raw", OFF_RAW, 32'h0);
                ticks(1);
                rdchk("R6 first raw", OFF_RAW, 32'h1);
                rdchk("R11 msk", OFF_MSK, 32'h1);
                check("R11 irq", 32'(irq), 32'h1);
                rdchk("R6 reload", OFF_COUNT, 32'(lv));
                check("R7 no early fire", 32'(rst_req), 32'h0);
                ticks(lv);
                check("R7 before second", 32'(rst_req), 32'h0);
                ticks(1);
                check("R7 second expiry", 32'(rst_req), 32'(re));
                rdchk("R7 raw kept", OFF_RAW, 32'h1);
                rdchk("R7 reload again", OFF_COUNT, 32'(lv));
                wr(OFF_ACK, 32'h0);
                if (re == 0) begin
                    rdchk("R9 clear raw", OFF_RAW, 32'h0);
                    check("R9 clear irq", 32'(irq), 32'h0);
                    rdchk("R9 clear reload", OFF_COUNT, 32'(lv));
                end else begin
                    check("R8 sticky", 32'(rst_req), 32'h1);
                    rdchk("R8 raw sticky", OFF_RAW, 32'h1);
                    ticks(5);
                    check("R8 still set", 32'(rst_req), 32'h1);
                end
            end
        end

        // R11 raw independent of enable
        do_reset();
        wr(OFF_GUARD, UNLOCK_KEY);
        wr(OFF_RELOAD, 32'h0);
        wr(OFF_CTRL, 32'h1);
        ticks(1);
        wr(OFF_CTRL, 32'h0);
        rdchk("R11 raw stays", OFF_RAW, 32'h1);
        rdchk("R11 msk off", OFF_MSK, 32'h0);
        check("R11 irq off", 32'(irq), 32'h0);
        wr(OFF_CTRL, 32'h2);
        ticks(3);
        check("R5 disabled no fire", 32'(rst_req), 32'h0);

        // R4 locked clear ignored
        wr(OFF_GUARD, 32'h0);
        wr(OFF_ACK, 32'h0);
        rdchk("R4 clear ignored", OFF_RAW, 32'h1);

        // R9 clear coinciding with an expiry
        do_reset();
        wr(OFF_GUARD, UNLOCK_KEY);
        wr(OFF_RELOAD, 32'h0);
        wr(OFF_CTRL, 32'h3);
        ticks(1);
        rdchk("R9 pending", OFF_RAW, 32'h1);
        wr(OFF_ACK, 32'h0, 1'b1);
        check("R9 clear wins", 32'(rst_req), 32'h0);
        rdchk("R9 raw cleared", OFF_RAW, 32'h0);
        rdchk("R9 count", OFF_COUNT, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule